// File: doc/BRIEF.md
# Myoelectric Contraction Detector with Bounded Travel Control

This block turns a stream of smoothed, rectified muscle-activity magnitudes into a motor command for a single-axis gripper. Each incoming sample that carries a valid strobe is compared against a programmable threshold. A contraction is flagged at once on the first sample above the threshold. The flag is held until a run of consecutive quiet samples of a set length has been seen. This stretching filters out short dips in the envelope.

The flag drives a travel controller. A position counter steps once per divided clock tick. It counts up toward a programmable travel limit while a contraction is flagged, and down toward zero otherwise. It never leaves the range from zero to the limit. The counter's motion selects a 2-bit direction code for an external motor driver. Counting up is the closing (grip) direction and counting down is the opening (return to rest) direction. The motor stops at the limit and at rest. Because of this, the gripper closes for a bounded time when the muscle contracts and returns by itself when the muscle relaxes.

Detector states: `DET_QUIET` moves to `DET_ACTIVE` on a valid sample above the threshold. `DET_ACTIVE` moves to `DET_QUIET` when a valid quiet sample completes a run of `HOLD_N` quiet samples. Travel states are decoded every cycle from the flag, the position and the limit:
- `TR_CLOSING`: flag high, position below the limit.
- `TR_HOLDING`: flag high, position at or above the limit.
- `TR_OPENING`: flag low, position nonzero.
- `TR_REST`: flag low, position zero.

Top module: `emg_motion_ctrl`

## Requirements
- R1: A sample counts as above the threshold only if `smp_data` is strictly greater than `thresh` (unsigned). A sample equal to the threshold counts as quiet. Samples are only looked at in cycles where `smp_valid` is 1.
- R2: A valid sample above the threshold sets `detect` to 1 on the next clock edge, whatever the previous state.
- R3: While `detect` is 1, it returns to 0 on the edge that takes in the `HOLD_N`-th consecutive valid quiet sample (default 50). A valid sample above the threshold restarts the run. Cycles without `smp_valid` neither extend nor restart the run.
- R4: A divider counts clock cycles from reset and produces one step tick every `TICK_DIV` cycles, in the cycle where its count is `TICK_DIV-1`. `position` changes only on the edge that ends a tick cycle, by at most one.
- R5: On a tick edge with `detect` 1 and `position` below `travel_lim`, `position` rises by one. With `detect` 1 and `position` at or above `travel_lim`, it does not change.
- R6: On a tick edge with `detect` 0 and `position` nonzero, `position` falls by one. At zero with `detect` 0, it stays at zero.
- R7: `motor_code` is 2'b01 (close) in `TR_CLOSING` and 2'b10 (open) in `TR_OPENING`. It is 2'b00 (stop) in `TR_HOLDING` and `TR_REST`. It is never 2'b11.
- R8: While `rst_n` is 0, `detect` is 0, `position` is 0 and `motor_code` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | DATA_W | Smoothed magnitude sample, unsigned |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| thresh | input | DATA_W | Contraction threshold, unsigned |
| travel_lim | input | POS_W | Maximum position count in the closing direction |
| detect | output | 1 | Stretched contraction flag |
| motor_code | output | 2 | Direction code: 01 close, 10 open, 00 stop |
| position | output | POS_W | Current travel counter value |

## Verification
A wrong count in the hold-off run shows on `detect`: it falls one or more valid samples early or late relative to the `HOLD_N`-th quiet sample. It can also fall too soon after a gap with no valid samples. A stuck or miscounted position is visible on `position` at the next tick edge. From there it shows in `motor_code` in the same cycle, as a wrong direction or as motion past zero or the limit. The bench runs an arithmetic model alongside the design and compares all three outputs in every cycle. It adds directed runs at the threshold equality point, at exactly `HOLD_N` quiet samples, at the travel limit (including a limit of zero and a limit lowered below the current position) and on the return to rest.

// File: rtl/emg_ctrl_pkg.sv
package emg_ctrl_pkg;

    typedef enum logic [1:0] {
        MC_STOP  = 2'b00,
        MC_CLOSE = 2'b01,
        MC_OPEN  = 2'b10
    } motor_code_e;

    typedef enum logic {
        DET_QUIET,
        DET_ACTIVE
    } det_state_e;

    typedef enum logic [1:0] {
        TR_REST,
        TR_CLOSING,
        TR_HOLDING,
        TR_OPENING
    } travel_state_e;

endpackage

// File: rtl/emg_step_tick.sv
module emg_step_tick #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV <= 1) begin : g_every_cycle
            assign tick = 1'b1;
        end else begin : g_divider
            logic [DIV_W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (cnt_q == DIV_W'(TICK_DIV - 1)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick = (cnt_q == DIV_W'(TICK_DIV - 1));

            // R4
            tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/emg_contraction_detect.sv
module emg_contraction_detect
    import emg_ctrl_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int HOLD_N = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] thresh,
    output logic              detect
);
    localparam int CNT_W = $clog2(HOLD_N + 1);
    localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(HOLD_N - 1);

    det_state_e       st_q, st_d;
    logic [CNT_W-1:0] run_q, run_d;
    logic             above;

    assign above = (smp_data > thresh);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DET_QUIET;
            run_q <= '0;
        end else begin
            st_q  <= st_d;
            run_q <= run_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        run_d = run_q;
        if (smp_valid) begin
            unique case (st_q)
                DET_QUIET: begin
                    if (above) begin
                        st_d  = DET_ACTIVE;
                        run_d = '0;
                    end
                end
                DET_ACTIVE: begin
                    if (above) begin
                        run_d = '0;
                    end else if (run_q == RUN_LAST) begin
                        st_d  = DET_QUIET;
                        run_d = '0;
                    end else begin
                        run_d = run_q + 1'b1;
                    end
                end
                default: st_d = DET_QUIET;
            endcase
        end
    end

    always_comb begin
        unique case (st_q)
            DET_ACTIVE: detect = 1'b1;
            default:    detect = 1'b0;
        endcase
    end

    // R2
    det_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (smp_data > thresh)) |=> detect);

    // R3
    det_gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && detect) |=> detect);

    // R3
    det_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(detect) |-> ($past(smp_valid) && ($past(smp_data) <= $past(thresh))));

endmodule

// File: rtl/emg_travel_limiter.sv
module emg_travel_limiter
    import emg_ctrl_pkg::*;
#(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             detect,
    input  logic [POS_W-1:0] travel_lim,
    output logic [POS_W-1:0] position,
    output logic [1:0]       motor_code
);
    travel_state_e    mode;
    logic [POS_W-1:0] pos_q, pos_d;
    motor_code_e      code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    always_comb begin
        if (detect) begin
            mode = (pos_q < travel_lim) ? TR_CLOSING : TR_HOLDING;
        end else begin
            mode = (pos_q != '0) ? TR_OPENING : TR_REST;
        end
    end

    always_comb begin
        pos_d = pos_q;
        code  = MC_STOP;
        unique case (mode)
            TR_CLOSING: begin
                code = MC_CLOSE;
                if (tick) pos_d = pos_q + 1'b1;
            end
            TR_OPENING: begin
                code = MC_OPEN;
                if (tick) pos_d = pos_q - 1'b1;
            end
            TR_HOLDING: code = MC_STOP;
            TR_REST:    code = MC_STOP;
            default:    code = MC_STOP;
        endcase
    end

    assign position   = pos_q;
    assign motor_code = code;

    // R4
    step_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(position));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (detect && (position >= travel_lim)) |=> $stable(position));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!detect && (position == '0)) |=> (position == '0));

    // R7
    close_moves_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (motor_code == 2'b01)) |=> (position == $past(position) + 1'b1));

    // R7
    open_moves_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (motor_code == 2'b10)) |=> (position == $past(position) - 1'b1));

endmodule

// File: rtl/emg_motion_ctrl.sv
module emg_motion_ctrl #(
    parameter int DATA_W   = 12,
    parameter int HOLD_N   = 50,
    parameter int POS_W    = 8,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] thresh,
    input  logic [POS_W-1:0]  travel_lim,
    output logic              detect,
    output logic [1:0]        motor_code,
    output logic [POS_W-1:0]  position
);
    logic step_tick;
    logic det_flag;

    emg_step_tick #(
        .TICK_DIV(TICK_DIV)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (step_tick)
    );

    emg_contraction_detect #(
        .DATA_W(DATA_W),
        .HOLD_N(HOLD_N)
    ) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_data (smp_data),
        .smp_valid(smp_valid),
        .thresh   (thresh),
        .detect   (det_flag)
    );

    emg_travel_limiter #(
        .POS_W(POS_W)
    ) u_travel (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (step_tick),
        .detect    (det_flag),
        .travel_lim(travel_lim),
        .position  (position),
        .motor_code(motor_code)
    );

    assign detect = det_flag;

    // R7
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        motor_code != 2'b11);

endmodule

// File: tb/test_emg_motion_ctrl.sv
module test_emg_motion_ctrl;
    localparam int DW = 12;
    localparam int HN = 50;
    localparam int PW = 8;
    localparam int TD = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] smp_data;
    logic          smp_valid;
    logic [DW-1:0] thresh;
    logic [PW-1:0] travel_lim;
    logic          detect;
    logic [1:0]    motor_code;
    logic [PW-1:0] position;

    int  checks = 0;
    int  fails  = 0;
    bit  cmp_en = 1'b0;
    bit  done   = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    emg_motion_ctrl #(
        .DATA_W(DW), .HOLD_N(HN), .POS_W(PW), .TICK_DIV(TD)
    ) i_emg_motion_ctrl (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
        .thresh(thresh), .travel_lim(travel_lim), .detect(detect),
        .motor_code(motor_code), .position(position)
    );

    // arithmetic reference built from the requirements
    logic          m_det;
    int            m_run;
    int            m_tc;
    logic [PW-1:0] m_pos;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_det <= 1'b0; m_run <= 0; m_tc <= 0; m_pos <= '0;
        end else begin
            if (smp_valid) begin
                if (smp_data > thresh) begin
                    m_det <= 1'b1; m_run <= 0;
                end else if (m_det) begin
                    if (m_run == HN - 1) begin
                        m_det <= 1'b0; m_run <= 0;
                    end else begin
                        m_run <= m_run + 1;
                    end
                end
            end
            m_tc <= (m_tc == TD - 1) ? 0 : m_tc + 1;
            if (m_tc == TD - 1) begin
                if (m_det && m_pos < travel_lim) m_pos <= m_pos + 1'b1;
                else if (!m_det && m_pos != 0) m_pos <= m_pos - 1'b1;
            end
        end
    end

    function automatic logic [1:0] exp_code(logic d, logic [PW-1:0] p, logic [PW-1:0] l);
        if (d && p < l) return 2'b01;
        if (!d && p != 0) return 2'b10;
        return 2'b00;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            chk(detect === m_det, "R2 R3 detect vs model", int'(detect), int'(m_det));
            chk(position === m_pos, "R4 R5 R6 position vs model", int'(position), int'(m_pos));
            chk(motor_code === exp_code(m_det, m_pos, travel_lim), "R7 code vs model",
                int'(motor_code), int'(exp_code(m_det, m_pos, travel_lim)));
        end
    end

    task automatic send(input logic [DW-1:0] v);
        smp_data  = v;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lfsr_step();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; smp_data = '0; smp_valid = 1'b0;
        thresh = 12'd100; travel_lim = 8'd6;
        idle(3);
        // R8
        chk(detect === 1'b0, "R8 reset detect", int'(detect), 0);
        chk(position === '0, "R8 reset position", int'(position), 0);
        chk(motor_code === 2'b00, "R8 reset code", int'(motor_code), 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R1 equality is quiet, one above triggers
        send(12'd100);
        chk(detect === 1'b0, "R1 equal to threshold", int'(detect), 0);
        send(12'd101);
        chk(detect === 1'b1, "R2 rise after above-threshold sample", int'(detect), 1);

        // R3 hold-off length and restart
        for (int i = 0; i < HN - 1; i++) send(12'd10);
        chk(detect === 1'b1, "R3 held after HOLD_N-1 quiet", int'(detect), 1);
        send(12'd200);
        for (int i = 0; i < HN - 1; i++) send(12'd100);
        chk(detect === 1'b1, "R3 restart by above sample", int'(detect), 1);
        idle(20);
        chk(detect === 1'b1, "R3 gaps do not count", int'(detect), 1);
        send(12'd5);
        chk(detect === 1'b0, "R3 release on HOLD_N-th quiet", int'(detect), 0);

        // R5 R7 travel up to the limit
        idle(40);
        send(12'd300);
        chk(motor_code === 2'b01, "R7 close while climbing", int'(motor_code), 1);
        idle(40);
        chk(position === 8'd6, "R5 saturate at limit", int'(position), 6);
        chk(motor_code === 2'b00, "R7 stop at limit", int'(motor_code), 0);
        travel_lim = 8'd3;
        idle(12);
        chk(position === 8'd6, "R5 no motion above lowered limit", int'(position), 6);
        for (int i = 0; i < HN; i++) send(12'd0);
        chk(motor_code === 2'b10 || position === '0, "R7 open while returning",
            int'(motor_code), 2);
        idle(40);
        chk(position === '0, "R6 return to rest", int'(position), 0);
        chk(motor_code === 2'b00, "R7 stop at rest", int'(motor_code), 0);
        idle(12);
        chk(position === '0, "R6 no underflow", int'(position), 0);

        // R5 limit of zero holds at rest while flagged
        travel_lim = 8'd0;
        send(12'd4000);
        idle(16);
        chk(position === '0 && motor_code === 2'b00, "R5 zero limit holds",
            int'(position), 0);

        // R1 R2 R3 R4 sweeps over thresholds and limits, compared every cycle
        foreach (thresh_set[k]) begin
            thresh = thresh_set[k];
            travel_lim = lim_set[k];
            for (int n = 0; n < 150; n++) begin
                lfsr_step();
                if (lfsr[15]) send(lfsr[11:0]);
                else send({4'b0, lfsr[7:0]});
                idle(int'(lfsr[1:0]));
            end
        end
        thresh = 12'd4095;
        for (int n = 0; n < 60; n++) begin
            lfsr_step();
            send(lfsr[11:0]);
        end
        idle(60);
        chk(detect === 1'b0, "R1 max threshold never triggers", int'(detect), 0);

        cmp_en = 1'b0;
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    logic [DW-1:0] thresh_set [4] = '{12'd0, 12'd64, 12'd180, 12'd2000};
    logic [PW-1:0] lim_set    [4] = '{8'd1, 8'd5, 8'd9, 8'd3};

endmodule